// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator Unit

The block holds two signed 40-bit accumulators, A and B. A strobed add puts a 40-bit two's-complement operand into the accumulator that the select line picks. Each accumulator has its own enable for clamping. One mode pin applies to both and picks the clamp point. In the narrow mode a result is limited to the 32-bit (1.31) range. In the wide mode it is limited to the full 40-bit (9.31) range. Software can load any accumulator one word at a time: an 8-bit top word, a 16-bit middle word and a 16-bit bottom word.

Each accumulator keeps two flags. The overflow flag says that the latest add left a value that does not fit in the low 32 bits. It is recomputed on every add. The saturation flag is sticky and records that a clamp point was crossed. Only the per-accumulator clear input resets it. The block also drives two combined flags, each the OR of the matching A and B flags. There is no stream interface: the operand is taken on any cycle with `add_en` high and nothing is held back. Every result is registered and shows on the outputs after the next rising clock edge.

Top module: `dual_sat_acc`

## Requirements
- R1: After reset both accumulators read zero and all six flag outputs read 0.
- R2: With clamping disabled, an add replaces the selected accumulator (acc_sel 0 = A, 1 = B) with (accumulator + operand) mod 2^40, and the other accumulator keeps its value.
- R3: In narrow mode (sat_super = 0) with the accumulator's clamp enabled, a sum above 0x007FFFFFFF gives 0x007FFFFFFF and a sum below 0xFF80000000 gives 0xFF80000000. Either case sets that accumulator's saturation flag.
- R4: In wide mode (sat_super = 1) with clamping enabled, a sum above 0x7FFFFFFFFF gives 0x7FFFFFFFFF and a sum below 0x8000000000 gives 0x8000000000, and the saturation flag is set. A sum inside the 40-bit range is stored unchanged, even when it needs more than 32 bits.
- R5: After each add, the overflow flag of that accumulator is 1 exactly when bits 39..31 of the stored result are not all equal. A later add that fits clears it again.
- R6: A sum outside the signed 40-bit range sets the saturation flag even when clamping is disabled. The stored value is then the wrapped value.
- R7: A saturation flag stays set until its clear input (clr_sat_a / clr_sat_b) is high on a clock edge. If a saturating add and the clear fall on the same edge, the flag stays set.
- R8: ovf_any equals ovf_a OR ovf_b, and sat_any equals sat_a OR sat_b, at all times.
- R9: On an edge where any of the word write enables is high, the accumulator named by wr_sel takes its words from wr_data. The top word is bits 39..32 and comes from wr_data[7:0]. The middle word is bits 31..16 and the bottom word is bits 15..0, each taken from wr_data[15:0]. On that edge an add to the same accumulator is ignored and its flags keep their values.
- R10: Each clamp enable acts only on its own accumulator: with sat_en_a = 1 and sat_en_b = 0, adds to B wrap and are not clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_en | input | 1 | Add strobe |
| acc_sel | input | 1 | Add target: 0 = A, 1 = B |
| operand | input | 40 | Signed addend |
| sat_en_a | input | 1 | Clamp enable for A |
| sat_en_b | input | 1 | Clamp enable for B |
| sat_super | input | 1 | Clamp point: 0 = 32-bit range, 1 = 40-bit range |
| wr_sel | input | 1 | Word write target: 0 = A, 1 = B |
| wr_up_en | input | 1 | Write bits 39..32 from wr_data[7:0] |
| wr_hi_en | input | 1 | Write bits 31..16 |
| wr_lo_en | input | 1 | Write bits 15..0 |
| wr_data | input | 16 | Word write data |
| clr_sat_a | input | 1 | Clear saturation flag of A |
| clr_sat_b | input | 1 | Clear saturation flag of B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A does not fit in 32 bits after last add |
| ovf_b | output | 1 | B does not fit in 32 bits after last add |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_any | output | 1 | ovf_a OR ovf_b |
| sat_any | output | 1 | sat_a OR sat_b |

## Verification
The assertions check the following on every cycle:
- a saturation flag never drops without its clear input;
- a clear that comes without an add always drops the flag;
- an add in narrow mode with clamping enabled never leaves the overflow flag set;
- a word write never disturbs the flags.

Only the bench's scenarios can show the following:
- the exact clamp values in both modes;
- wrap-around with clamping disabled, and the sticky flag it sets;
- the overflow flag being recomputed rather than held;
- the write-over-add priority;
- the independence of the two clamp enables.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int ACC_W  = 40;
  localparam int FIT_W  = 32;
  localparam int WORD_W = 16;
  localparam int N_ACC  = 2;
  typedef enum logic {CLAMP_NARROW = 1'b0, CLAMP_WIDE = 1'b1} clamp_mode_e;
endpackage

// File: rtl/dsa_addsat.sv
module dsa_addsat #(
  parameter int W   = 40,
  parameter int FIT = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic         clamp_en,
  input  logic         wide_mode,
  output logic [W-1:0] result,
  output logic         sat_hit,
  output logic         ovf
);
  localparam int GUARD = W - FIT + 1;
  localparam logic [W-1:0] NAR_MAX = {{GUARD{1'b0}}, {(FIT-1){1'b1}}};
  localparam logic [W-1:0] NAR_MIN = ~NAR_MAX;
  localparam logic [W-1:0] WID_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WID_MIN = ~WID_MAX;

  logic [W:0] sum;
  logic       wide_out, nar_out, out_rng;

  always_comb begin
    sum      = {acc[W-1], acc} + {addend[W-1], addend};
    wide_out = sum[W] ^ sum[W-1];
    nar_out  = !((&sum[W:FIT-1]) || !(|sum[W:FIT-1]));
    out_rng  = wide_mode ? wide_out : nar_out;
    if (clamp_en && out_rng) begin
      if (wide_mode) result = sum[W] ? WID_MIN : WID_MAX;
      else           result = sum[W] ? NAR_MIN : NAR_MAX;
    end else begin
      result = sum[W-1:0];
    end
    sat_hit = (clamp_en && out_rng) || wide_out;
    ovf     = !((&result[W-1:FIT-1]) || !(|result[W-1:FIT-1]));
  end
endmodule

// File: rtl/dsa_acc_reg.sv
module dsa_acc_reg #(
  parameter int W   = 40,
  parameter int FIT = 32,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_go,
  input  logic [W-1:0]  addend,
  input  logic          clamp_en,
  input  logic          wide_mode,
  input  logic          wr_up,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_sat,
  output logic [W-1:0]  acc_q,
  output logic          ovf_q,
  output logic          sat_q
);
  localparam int HI_LSB = DW;
  localparam int UP_LSB = 2 * DW;
  localparam int UP_W   = W - UP_LSB;

  logic [W-1:0] sum_res;
  logic         hit, ovf_n, wr_any, add_ok;

  assign wr_any = wr_up || wr_hi || wr_lo;
  assign add_ok = add_go && !wr_any;

  dsa_addsat #(.W(W), .FIT(FIT)) u_addsat (
    .acc(acc_q), .addend(addend), .clamp_en(clamp_en), .wide_mode(wide_mode),
    .result(sum_res), .sat_hit(hit), .ovf(ovf_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (wr_any) begin
        if (wr_up) acc_q[W-1:UP_LSB]      <= wr_data[UP_W-1:0];
        if (wr_hi) acc_q[UP_LSB-1:HI_LSB] <= wr_data;
        if (wr_lo) acc_q[HI_LSB-1:0]      <= wr_data;
      end else if (add_go) begin
        acc_q <= sum_res;
        ovf_q <= ovf_n;
      end
      if (add_ok && hit) sat_q <= 1'b1;
      else if (clr_sat)  sat_q <= 1'b0;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q && !clr_sat |=> sat_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sat && !add_go |=> !sat_q);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    add_ok && clamp_en && !wide_mode |=> !ovf_q);
  assert_write_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && !clr_sat |=> $stable(ovf_q) && $stable(sat_q));
endmodule

// File: rtl/dual_sat_acc.sv
module dual_sat_acc
  import dsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic              acc_sel,
  input  logic [ACC_W-1:0]  operand,
  input  logic              sat_en_a,
  input  logic              sat_en_b,
  input  logic              sat_super,
  input  logic              wr_sel,
  input  logic              wr_up_en,
  input  logic              wr_hi_en,
  input  logic              wr_lo_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_sat_a,
  input  logic              clr_sat_b,
  output logic [ACC_W-1:0]  acc_a,
  output logic [ACC_W-1:0]  acc_b,
  output logic              ovf_a,
  output logic              ovf_b,
  output logic              sat_a,
  output logic              sat_b,
  output logic              ovf_any,
  output logic              sat_any
);
  logic [N_ACC-1:0]            clamp_en, clr_v, ovf_v, sat_v;
  logic [N_ACC-1:0][ACC_W-1:0] acc_v;
  clamp_mode_e                 mode;

  assign mode     = clamp_mode_e'(sat_super);
  assign clamp_en = {sat_en_b, sat_en_a};
  assign clr_v    = {clr_sat_b, clr_sat_a};

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    logic hit_sel, wr_this;
    assign hit_sel = add_en && (acc_sel == i[0]);
    assign wr_this = (wr_sel == i[0]);
    dsa_acc_reg #(.W(ACC_W), .FIT(FIT_W), .DW(WORD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .add_go(hit_sel), .addend(operand),
      .clamp_en(clamp_en[i]), .wide_mode(mode == CLAMP_WIDE),
      .wr_up(wr_up_en && wr_this), .wr_hi(wr_hi_en && wr_this),
      .wr_lo(wr_lo_en && wr_this), .wr_data(wr_data), .clr_sat(clr_v[i]),
      .acc_q(acc_v[i]), .ovf_q(ovf_v[i]), .sat_q(sat_v[i])
    );
  end

  assign acc_a   = acc_v[0];
  assign acc_b   = acc_v[1];
  assign ovf_a   = ovf_v[0];
  assign ovf_b   = ovf_v[1];
  assign sat_a   = sat_v[0];
  assign sat_b   = sat_v[1];
  assign ovf_any = |ovf_v;
  assign sat_any = |sat_v;
endmodule

// File: tb/dual_sat_acc_tb_top.sv
`timescale 1ns/1ps
module dual_sat_acc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic add_en = 0, acc_sel = 0, sat_en_a = 0, sat_en_b = 0, sat_super = 0;
  logic wr_sel = 0, wr_up_en = 0, wr_hi_en = 0, wr_lo_en = 0;
  logic clr_sat_a = 0, clr_sat_b = 0;
  logic [39:0] operand = '0;
  logic [15:0] wr_data = '0;
  logic [39:0] acc_a, acc_b;
  logic ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any;

  int n_chk = 0, n_bad = 0;
  logic [39:0] e_acc [2];
  logic        e_ovf [2];
  logic        e_sat [2];

  always #2.5 clk = ~clk;

  dual_sat_acc dut_i (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .acc_sel(acc_sel), .operand(operand),
    .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_super(sat_super), .wr_sel(wr_sel),
    .wr_up_en(wr_up_en), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en), .wr_data(wr_data),
    .clr_sat_a(clr_sat_a), .clr_sat_b(clr_sat_b), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b),
    .ovf_any(ovf_any), .sat_any(sat_any)
  );

  task automatic cmp(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " acc_a"}, acc_a, e_acc[0]);
    cmp({tag, " acc_b"}, acc_b, e_acc[1]);
    cmp({tag, " ovf_a"}, {39'd0, ovf_a}, {39'd0, e_ovf[0]});
    cmp({tag, " ovf_b"}, {39'd0, ovf_b}, {39'd0, e_ovf[1]});
    cmp({tag, " sat_a"}, {39'd0, sat_a}, {39'd0, e_sat[0]});
    cmp({tag, " sat_b"}, {39'd0, sat_b}, {39'd0, e_sat[1]});
    cmp({tag, " R8 ovf_any"}, {39'd0, ovf_any}, {39'd0, e_ovf[0] | e_ovf[1]});
    cmp({tag, " R8 sat_any"}, {39'd0, sat_any}, {39'd0, e_sat[0] | e_sat[1]});
  endtask

  // Expected result of one add, worked out from R2..R6.
  task automatic model_add(input int s, input logic [39:0] op, input logic en,
                           input logic wide, input logic clr);
    longint sum, hi, lo;
    logic   out, hit;
    logic [39:0] r;
    sum = longint'($signed(e_acc[s])) + longint'($signed(op));
    hi  = wide ? 64'sh7F_FFFF_FFFF : 64'sh7FFF_FFFF;
    lo  = wide ? -64'sh80_0000_0000 : -64'sh8000_0000;
    out = (sum > hi) || (sum < lo);
    if (en && out) r = (sum > hi) ? hi[39:0] : lo[39:0];
    else           r = sum[39:0];
    hit = (en && out) || (sum > 64'sh7F_FFFF_FFFF) || (sum < -64'sh80_0000_0000);
    e_acc[s] = r;
    e_ovf[s] = !((&r[39:31]) || !(|r[39:31]));
    if (hit) e_sat[s] = 1'b1;
    else if (clr) e_sat[s] = 1'b0;
  endtask

  task automatic do_add(input int s, input logic [39:0] op, input logic clr, input string tag);
    logic en;
    en = (s == 0) ? sat_en_a : sat_en_b;
    model_add(s, op, en, sat_super, clr);
    add_en = 1; acc_sel = s[0]; operand = op;
    if (s == 0) clr_sat_a = clr; else clr_sat_b = clr;
    @(negedge clk);
    add_en = 0; clr_sat_a = 0; clr_sat_b = 0;
    check_all(tag);
  endtask

  task automatic load(input int s, input logic [39:0] v);
    wr_sel = s[0]; wr_up_en = 1; wr_hi_en = 1; wr_lo_en = 1;
    wr_data = {8'd0, v[39:32]};
    @(negedge clk);
    wr_up_en = 0; wr_lo_en = 0; wr_data = v[31:16];
    @(negedge clk);
    wr_hi_en = 0; wr_lo_en = 1; wr_data = v[15:0];
    @(negedge clk);
    wr_lo_en = 0;
    e_acc[s] = v;
  endtask

  task automatic clr_flag(input int s);
    if (s == 0) clr_sat_a = 1; else clr_sat_b = 1;
    @(negedge clk);
    clr_sat_a = 0; clr_sat_b = 0;
    e_sat[s] = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin e_acc[i] = '0; e_ovf[i] = 0; e_sat[i] = 0; end
    check_all("R1 reset");
  endtask

  task automatic t_wrap;
    sat_en_a = 0; sat_en_b = 0; sat_super = 0;
    do_add(0, 40'd5, 0, "R2 add");
    do_add(0, -40'sd3, 0, "R2 add negative");
    cmp("R2 value", acc_a, 40'd2);
    load(1, 40'h7F_FFFF_FFFF);
    do_add(1, 40'd1, 0, "R6 wrap sets sat");
    cmp("R6 wrapped value", acc_b, 40'h80_0000_0000);
  endtask

  task automatic t_write;
    load(0, 40'h12_3456_789A);
    check_all("R9 word load");
    wr_sel = 0; wr_up_en = 1; wr_data = 16'h00C3; add_en = 1; acc_sel = 0; operand = 40'd1;
    @(negedge clk);
    wr_up_en = 0; add_en = 0;
    e_acc[0] = 40'hC3_3456_789A;
    check_all("R9 write beats add");
  endtask

  task automatic t_normal;
    clr_flag(0); clr_flag(1);
    sat_en_a = 1; sat_super = 0;
    load(0, 40'h00_7FFF_FFF0);
    do_add(0, 40'h20, 0, "R3 clamp positive");
    cmp("R3 max", acc_a, 40'h00_7FFF_FFFF);
    clr_flag(0);
    load(0, 40'hFF_8000_0000);
    do_add(0, -40'sd1, 0, "R3 clamp negative");
    cmp("R3 min", acc_a, 40'hFF_8000_0000);
  endtask

  task automatic t_ovf;
    clr_flag(0); sat_en_a = 0;
    load(0, 40'h00_7FFF_FFFF);
    do_add(0, 40'd1, 0, "R5 overflow set");
    do_add(0, -40'sd1, 0, "R5 overflow recomputed");
  endtask

  task automatic t_super;
    sat_en_a = 1; sat_super = 1; clr_flag(0);
    load(0, 40'h00_0000_0000);
    do_add(0, 40'h01_0000_0000, 0, "R4 in range unclamped");
    load(0, 40'h7F_0000_0000);
    do_add(0, 40'h01_0000_0000, 0, "R4 clamp positive");
    load(0, 40'h80_0000_0010);
    do_add(0, -40'sh20, 0, "R4 clamp negative");
  endtask

  task automatic t_sticky;
    sat_super = 0;
    do_add(0, 40'd0, 0, "R7 flag holds");
    clr_flag(0);
    check_all("R7 flag cleared");
    load(0, 40'h00_7FFF_FFFF);
    do_add(0, 40'd5, 1, "R7 set beats clear");
  endtask

  task automatic t_indep;
    sat_en_a = 1; sat_en_b = 0; sat_super = 0; clr_flag(1);
    load(1, 40'h00_7FFF_FFFF);
    do_add(1, 40'd1, 0, "R10 B not clamped");
    cmp("R10 B value", acc_b, 40'h00_8000_0000);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_write();
    t_normal();
    t_ovf();
    t_super();
    t_sticky();
    t_indep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule